// File: doc/BRIEF.md
# Newline-Framed Text Row Assembler

This block gathers a stream of 8-bit text characters into one wide row register. A character is taken on each clock in which the byte-valid strobe is high, and the strobe may stay low for any number of cycles between characters. Each taken character that is not a line terminator goes into the next free character slot of an internal row buffer.

When a line-feed character arrives, the buffered row is copied into a parallel output register together with its character count, and a start strobe is raised for one cycle. A downstream stage that works on a whole row at once can use the row in that cycle. The internal buffer is then emptied, so the next line starts from slot zero and has no leftover characters. Carriage returns are dropped. Characters past the buffer capacity are discarded and set a sticky overflow flag.

At the default size the parallel row holds 256 characters (2048 bits). The external interface needs only the data byte, the strobe, clock and reset.

Top module: `line_assembler`

## Requirements
- R1: While reset is asserted and after it is released, `row_start` is 0, `row_len` is 0, `row_data` is all zero and `overflow` is 0 until a character is accepted.
- R2: A byte is accepted only on a rising clock edge where `in_valid` is 1. Idle cycles of any length between bytes neither drop nor repeat a character.
- R3: The k-th stored character of a line (k counted from 0) appears at `row_data[8k+7:8k]`.
- R4: The line-feed code 0x0A ends a line. `row_start` is 1 in the cycle after the edge that accepted it and 0 in any cycle not preceded by such an edge. `row_data` and `row_len` change only in that cycle and hold their value until the next line ends.
- R5: The carriage-return code 0x0D is discarded. It is neither stored nor counted, and it does not advance the slot index.
- R6: After a line ends, the buffer is cleared and storing restarts at slot 0. Slots a shorter following line does not fill read as zero in its emitted row.
- R7: `row_len` equals the number of characters stored for the emitted line, capped at `MAX_CHARS`.
- R8: A character that arrives when `MAX_CHARS` characters are already stored is dropped. It sets `overflow`, which stays 1 until reset.
- R9: A line feed with no stored characters still produces a one-cycle `row_start`, with `row_len` 0 and `row_data` all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_byte | input | 8 | Character code |
| in_valid | input | 1 | High in each cycle in which `in_byte` carries a character |
| row_data | output | 8*MAX_CHARS | Emitted row, character k at bits [8k+7:8k] |
| row_start | output | 1 | One-cycle strobe marking a freshly emitted row |
| row_len | output | $clog2(MAX_CHARS+1) | Number of characters in the emitted row |
| overflow | output | 1 | Sticky flag: a character was dropped for lack of space |

## Verification
The hardest situation to reach from the ports is a full buffer followed by more characters and then by a shorter line. This is where the capacity cap, the sticky flag and the clearing of stale slots all interact. The bench is built with a small capacity so that lines longer than the buffer are cheap to send. Directed lines longer than capacity are followed by short lines and empty lines. Random traffic then mixes long runs, carriage returns, back-to-back line feeds and idle gaps, while a behavioural queue model is compared against every output on every cycle.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam logic [7:0] CHAR_LF = 8'h0A;
  localparam logic [7:0] CHAR_CR = 8'h0D;

  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_DATA = 2'd1,
    KIND_CR   = 2'd2,
    KIND_LF   = 2'd3
  } beat_kind_e;
endpackage

// File: rtl/lsa_classify.sv
module lsa_classify
  import lsa_pkg::*;
(
  input  logic [7:0]  in_byte,
  input  logic        in_valid,
  output beat_kind_e  kind,
  output logic        beat_data,
  output logic        beat_lf
);
  always_comb begin
    if (!in_valid)                 kind = KIND_IDLE;
    else if (in_byte == CHAR_LF)   kind = KIND_LF;
    else if (in_byte == CHAR_CR)   kind = KIND_CR;
    else                           kind = KIND_DATA;
  end

  assign beat_data = (kind == KIND_DATA);
  assign beat_lf   = (kind == KIND_LF);
endmodule

// File: rtl/lsa_index_ctrl.sv
module lsa_index_ctrl #(
  parameter int MAX_CHARS = 256,
  localparam int IDX_W    = $clog2(MAX_CHARS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_data,
  input  logic             beat_lf,
  input  logic             beat_cr,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_en,
  output logic             overflow
);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(MAX_CHARS);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ovf_q, ovf_d;
  logic             room;

  assign room  = (idx_q != IDX_FULL);
  assign wr_en = beat_data && room;

  always_comb begin
    idx_d = idx_q;
    ovf_d = ovf_q;
    if (beat_lf)
      idx_d = '0;
    else if (wr_en)
      idx_d = idx_q + 1'b1;
    if (beat_data && !room)
      ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      ovf_q <= ovf_d;
    end
  end

  assign wr_idx   = idx_q;
  assign overflow = ovf_q;

  p_idx_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_lf |=> (idx_q == '0));
  p_cr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_cr |=> $stable(idx_q));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_data && !beat_lf) |=> $stable(idx_q));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_FULL);
endmodule

// File: rtl/lsa_lane_buf.sv
module lsa_lane_buf #(
  parameter int MAX_CHARS = 256,
  localparam int IDX_W    = $clog2(MAX_CHARS + 1),
  localparam int ROW_W    = 8 * MAX_CHARS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       wr_byte,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             clear,
  output logic [ROW_W-1:0] line_buf
);
  for (genvar k = 0; k < MAX_CHARS; k++) begin : g_lane
    logic [7:0] lane_q, lane_d;
    logic       lane_en;

    assign lane_en = clear || (wr_en && (wr_idx == IDX_W'(k)));

    always_comb begin
      lane_d = clear ? 8'h00 : wr_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= 8'h00;
      else if (lane_en)
        lane_q <= lane_d;
    end

    assign line_buf[8*k +: 8] = lane_q;
  end
endmodule

// File: rtl/line_assembler.sv
module line_assembler
  import lsa_pkg::*;
#(
  parameter int MAX_CHARS = 256,
  localparam int LEN_W    = $clog2(MAX_CHARS + 1),
  localparam int ROW_W    = 8 * MAX_CHARS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_byte,
  input  logic             in_valid,
  output logic [ROW_W-1:0] row_data,
  output logic             row_start,
  output logic [LEN_W-1:0] row_len,
  output logic             overflow
);
  beat_kind_e       kind;
  logic             beat_data, beat_lf, beat_cr;
  logic [LEN_W-1:0] wr_idx;
  logic             wr_en;
  logic [ROW_W-1:0] line_buf;

  logic [ROW_W-1:0] row_q, row_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             start_q, start_d;

  lsa_classify u_classify (
    .in_byte   (in_byte),
    .in_valid  (in_valid),
    .kind      (kind),
    .beat_data (beat_data),
    .beat_lf   (beat_lf)
  );

  assign beat_cr = (kind == KIND_CR);

  lsa_index_ctrl #(.MAX_CHARS(MAX_CHARS)) u_index (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_data (beat_data),
    .beat_lf   (beat_lf),
    .beat_cr   (beat_cr),
    .wr_idx    (wr_idx),
    .wr_en     (wr_en),
    .overflow  (overflow)
  );

  lsa_lane_buf #(.MAX_CHARS(MAX_CHARS)) u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_byte  (in_byte),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .clear    (beat_lf),
    .line_buf (line_buf)
  );

  always_comb begin
    start_d = beat_lf;
    row_d   = beat_lf ? line_buf : row_q;
    len_d   = beat_lf ? wr_idx   : len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      row_q   <= '0;
      len_q   <= '0;
    end else begin
      start_q <= start_d;
      row_q   <= row_d;
      len_q   <= len_d;
    end
  end

  assign row_data  = row_q;
  assign row_start = start_q;
  assign row_len   = len_q;

  p_start_after_lf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(in_valid && (in_byte == CHAR_LF)));
  p_row_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !start_q |-> ($stable(row_q) && $stable(len_q)));
  p_len_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_W'(MAX_CHARS));
  p_empty_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && (len_q == '0)) |-> (row_q == '0));
  p_one_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({beat_data, beat_lf, beat_cr}));
endmodule

// File: tb/line_assembler_test.sv
module line_assembler_test;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CHARS   = 16;
  localparam int LEN_W      = $clog2(TB_CHARS + 1);
  localparam int ROW_W      = 8 * TB_CHARS;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [7:0]       in_byte;
  logic             in_valid;
  logic [ROW_W-1:0] row_data;
  logic             row_start;
  logic [LEN_W-1:0] row_len;
  logic             overflow;

  int n_tests = 0;
  int n_fail  = 0;

  line_assembler #(.MAX_CHARS(TB_CHARS)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_byte   (in_byte),
    .in_valid  (in_valid),
    .row_data  (row_data),
    .row_start (row_start),
    .row_len   (row_len),
    .overflow  (overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  byte unsigned     line_q[$];
  logic [ROW_W-1:0] exp_row;
  logic             exp_start;
  int               exp_len;
  logic             exp_ovf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q.delete();
      exp_row = '0; exp_start = 1'b0; exp_len = 0; exp_ovf = 1'b0;
    end else begin
      exp_start = 1'b0;
      if (in_valid) begin
        if (in_byte == 8'h0A) begin
          exp_row = '0;
          foreach (line_q[i]) exp_row[8*i +: 8] = line_q[i];
          exp_len   = line_q.size();
          exp_start = 1'b1;
          line_q.delete();
        end else if (in_byte != 8'h0D) begin
          if (line_q.size() < TB_CHARS) line_q.push_back(in_byte);
          else exp_ovf = 1'b1;
        end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      n_tests++;
      if (row_start !== exp_start) begin
        n_fail++;
        $display("FAIL R4 row_start act=%0b exp=%0b", row_start, exp_start);
      end
      if (row_data !== exp_row) begin
        n_fail++;
        $display("FAIL R3/R6 row_data act=%h exp=%h", row_data, exp_row);
      end
      if (row_len !== LEN_W'(exp_len)) begin
        n_fail++;
        $display("FAIL R7 row_len act=%0d exp=%0d", row_len, exp_len);
      end
      if (overflow !== exp_ovf) begin
        n_fail++;
        $display("FAIL R8 overflow act=%0b exp=%0b", overflow, exp_ovf);
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b, int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'hFF;
    end
  endtask

  task automatic send_str(string s, int gap);
    for (int i = 0; i < s.len(); i++) put(s[i], gap);
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = 8'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 start", 64'(row_start), 64'd0);
    check("R1 len", 64'(row_len), 64'd0);
    check("R1 data", 64'(row_data[63:0]), 64'd0);
    check("R1 ovf", 64'(overflow), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", 64'({row_start, overflow}), 64'd0);

    // R2 R3 R7: gapped bytes
    send_str("ab", 3);
    put(8'h0A, 0);
    settle();
    check("R2 start", 64'(row_start), 64'd1);
    check("R7 len", 64'(row_len), 64'd2);
    check("R3 slot0", 64'(row_data[7:0]), 64'h61);
    check("R2 slots01", 64'(row_data[15:0]), 64'h6261);
    @(negedge clk);
    check("R4 single pulse", 64'(row_start), 64'd0);
    check("R4 row held", 64'(row_data[15:0]), 64'h6261);

    // R5: carriage return discarded
    send_str("xy", 0);
    put(8'h0D, 0);
    put(8'h0A, 0);
    settle();
    check("R5 len", 64'(row_len), 64'd2);
    check("R5 slot1", 64'(row_data[15:8]), 64'h79);
    check("R5 slot2", 64'(row_data[23:16]), 64'h00);

    // R6: shorter line after longer one
    send_str("abcdefgh", 1);
    put(8'h0A, 2);
    send_str("z", 0);
    put(8'h0A, 0);
    settle();
    check("R6 slot0", 64'(row_data[7:0]), 64'h7A);
    check("R6 stale cleared", 64'(row_data[63:8]), 64'd0);

    // R9: empty line
    put(8'h0A, 0);
    settle();
    check("R9 start", 64'(row_start), 64'd1);
    check("R9 len", 64'(row_len), 64'd0);
    check("R9 data", 64'(row_data[63:0]), 64'd0);

    // R8: overflow then shorter line
    check("R8 ovf before", 64'(overflow), 64'd0);
    send_str("0123456789ABCDEFGHIJ", 0);
    put(8'h0A, 0);
    settle();
    check("R8 ovf set", 64'(overflow), 64'd1);
    check("R8 len capped", 64'(row_len), 64'd16);
    check("R8 last slot", 64'(row_data[127:120]), 64'h46);
    send_str("q", 0);
    put(8'h0A, 0);
    settle();
    check("R8 ovf sticky", 64'(overflow), 64'd1);
    check("R8 next line len", 64'(row_len), 64'd1);

    // random traffic, checked every cycle by the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [7:0] b;
      r = $urandom_range(0, 99);
      if (r < 10)      b = 8'h0A;
      else if (r < 15) b = 8'h0D;
      else             b = 8'(8'h61 + $urandom_range(0, 25));
      put(b, $urandom_range(0, 3) == 0 ? $urandom_range(1, 4) : 0);
    end
    settle();
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule